// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block keeps an asynchronous DRAM alive by issuing refresh cycles at a steady average rate. An interval timer adds one owed refresh every `TICK_CYCLES` clocks to a bounded backlog counter. While anything is owed, the block raises a request to the access controller. The controller answers with a grant once no page is open. The block then takes over the RAS, CAS and WE strobes and plays one complete refresh cycle on them. For example, 2048 refreshes every 32.8 ms works out to one tick about every 16 µs.

In the default mode the sequence lowers CAS ahead of RAS. The device then refreshes the row chosen by its own internal counter, no address is driven, and the data pins stay high-impedance. A parameter selects the alternative RAS-only mode instead. In that mode CAS stays high for the whole sequence, and the block supplies the row from its own `ROW_BITS`-wide counter, with a flag that tells the board-level mux to route the row onto the address pins.

Owed refreshes that pile up while the controller is busy are kept in the backlog, up to `BACKLOG_MAX`. When the backlog reaches `URGENT_LEVEL`, an urgency flag tells the controller that refresh must now win arbitration. The strobes are meant to be multiplexed with the controller's own strobes under `ownsBus`.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and straight after reset, `rasN`, `casN` and `weN` are high, and `reqOut`, `urgentOut`, `ownsBus` and `addrDrive` are low.
- R2: An owed refresh is added once every `TICK_CYCLES` clocks, the first one at the `TICK_CYCLES`-th rising edge after reset is released. `reqOut` is high exactly while the owed count is non-zero.
- R3: The owed count saturates at `BACKLOG_MAX`. Ticks that arrive at the limit are dropped, so a full backlog drains in exactly `BACKLOG_MAX` sequences.
- R4: `urgentOut` is high exactly while the owed count is at least `URGENT_LEVEL`.
- R5: A sequence starts only from idle, at a rising edge where `reqOut` and `grantIn` are both high. `ownsBus` is high from the next cycle. With the grant held, sequences repeat with one idle cycle between them.
- R6: In CAS-before-RAS mode a sequence has four phases, in this order:
  - one cycle with all strobes high;
  - `SETUP_CYC` cycles with `casN` low and `rasN` high;
  - `RAS_LOW_CYC` cycles with both low;
  - `PRE_CYC` cycles with all strobes high.

  `weN` stays high throughout.
- R7: Once started, a sequence completes even if `grantIn` drops. The owed count drops by one at the cycle where `ownsBus` falls.
- R8: In CAS-before-RAS mode, `addrDrive` is always low and `rowAddr` is always zero.
- R9: In RAS-only mode, `casN` stays high, and `addrDrive` is high while `ownsBus` is high. `rowAddr` starts at 0 after reset and advances by one at the end of each sequence.
- R10: A grant with nothing owed starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grantIn | input | 1 | Access controller allows a refresh to start |
| reqOut | output | 1 | At least one refresh is owed |
| urgentOut | output | 1 | Backlog at or above the urgency level |
| rasN | output | 1 | Row strobe, active low, valid while `ownsBus` |
| casN | output | 1 | Column strobe, active low, valid while `ownsBus` |
| weN | output | 1 | Write enable, held high |
| ownsBus | output | 1 | Select for the strobe mux: block is running a sequence |
| addrDrive | output | 1 | Select for the address mux (RAS-only mode) |
| rowAddr | output | ROW_BITS | Row to refresh in RAS-only mode |

## Verification
The hardest state to reach from the ports is a saturated backlog. Reaching it requires holding off the grant for more ticks than `BACKLOG_MAX`. The effect only shows up later, as the number of sequences needed to drain the backlog. The bench shortens the tick interval, withholds the grant for six ticks, and then grants inside a window where no further tick can land. This lets it count exactly four RAS falls before the request drops. A second instance, in RAS-only mode, drains its own saturated backlog so that the row counter can be watched advancing.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  localparam int PHASE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_PRECHARGE
  } seqState_t;

  typedef struct packed {
    logic               phaseLoad;
    logic [PHASE_W-1:0] phaseVal;
    logic               refreshDone;
  } ctrlStrobe_t;

  typedef struct packed {
    logic pendingAny;
    logic pendingUrgent;
    logic phaseZero;
  } dpStatus_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import dram_rfsh_pkg::*;
#(
  parameter int TICK_CYCLES  = 800,
  parameter int BACKLOG_MAX  = 8,
  parameter int URGENT_LEVEL = 4,
  parameter int ROW_BITS     = 11,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         ctrl,
  output dpStatus_t           status,
  output logic [ROW_BITS-1:0] rowAddr
);

  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int PEND_W = $clog2(BACKLOG_MAX + 1);
  localparam logic [TICK_W-1:0] TICK_LAST   = TICK_W'(TICK_CYCLES - 1);
  localparam logic [PEND_W-1:0] PEND_MAX    = PEND_W'(BACKLOG_MAX);
  localparam logic [PEND_W-1:0] PEND_URGENT = PEND_W'(URGENT_LEVEL);

  logic [TICK_W-1:0]  tickCnt;
  logic               tickHit;
  logic [PEND_W-1:0]  pending;
  logic               pendInc;
  logic               pendDec;
  logic [PHASE_W-1:0] phaseCnt;

  // interval timer
  assign tickHit = (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickHit) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  // bounded backlog of owed refreshes
  assign pendInc = tickHit && (pending != PEND_MAX);
  assign pendDec = ctrl.refreshDone && (pending != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      case ({pendInc, pendDec})
        2'b10:   pending <= pending + PEND_W'(1);
        2'b01:   pending <= pending - PEND_W'(1);
        default: pending <= pending;
      endcase
    end
  end

  // phase length counter for the control sequence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctrl.phaseLoad) begin
      phaseCnt <= ctrl.phaseVal;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - PHASE_W'(1);
    end
  end

  assign status.pendingAny    = (pending != '0);
  assign status.pendingUrgent = (pending >= PEND_URGENT);
  assign status.phaseZero     = (phaseCnt == '0);

  // external row counter only exists in RAS-only mode
  generate
    if (RAS_ONLY) begin : g_rowCounter
      logic [ROW_BITS-1:0] rowCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rowCnt <= '0;
        end else if (ctrl.refreshDone) begin
          rowCnt <= rowCnt + ROW_BITS'(1);
        end
      end
      assign rowAddr = rowCnt;
    end else begin : g_internalRow
      assign rowAddr = '0;
    end
  endgenerate

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import dram_rfsh_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2,
  parameter bit RAS_ONLY    = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        grantIn,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output logic        rasN,
  output logic        casN,
  output logic        ownsBus
);

  localparam logic [PHASE_W-1:0] SETUP_LOAD = PHASE_W'(SETUP_CYC - 1);
  localparam logic [PHASE_W-1:0] RAS_LOAD   = PHASE_W'(RAS_LOW_CYC - 1);
  localparam logic [PHASE_W-1:0] PRE_LOAD   = PHASE_W'(PRE_CYC - 1);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (status.pendingAny && grantIn) begin
          stateNext = ST_ARM;
        end
      end
      ST_ARM: begin
        ctrl.phaseLoad = 1'b1;
        if (RAS_ONLY) begin
          stateNext     = ST_RAS_LOW;
          ctrl.phaseVal = RAS_LOAD;
        end else begin
          stateNext     = ST_CAS_SETUP;
          ctrl.phaseVal = SETUP_LOAD;
        end
      end
      ST_CAS_SETUP: begin
        if (status.phaseZero) begin
          stateNext      = ST_RAS_LOW;
          ctrl.phaseLoad = 1'b1;
          ctrl.phaseVal  = RAS_LOAD;
        end
      end
      ST_RAS_LOW: begin
        if (status.phaseZero) begin
          stateNext      = ST_PRECHARGE;
          ctrl.phaseLoad = 1'b1;
          ctrl.phaseVal  = PRE_LOAD;
        end
      end
      ST_PRECHARGE: begin
        if (status.phaseZero) begin
          stateNext        = ST_IDLE;
          ctrl.refreshDone = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      ownsBus <= 1'b0;
    end else begin
      state   <= stateNext;
      rasN    <= (stateNext != ST_RAS_LOW);
      casN    <= RAS_ONLY ||
                 !((stateNext == ST_CAS_SETUP) || (stateNext == ST_RAS_LOW));
      ownsBus <= (stateNext != ST_IDLE);
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int TICK_CYCLES  = 800,
  parameter int BACKLOG_MAX  = 8,
  parameter int URGENT_LEVEL = 4,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_LOW_CYC  = 3,
  parameter int PRE_CYC      = 2,
  parameter int ROW_BITS     = 11,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                grantIn,
  output logic                reqOut,
  output logic                urgentOut,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic                ownsBus,
  output logic                addrDrive,
  output logic [ROW_BITS-1:0] rowAddr
);

  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  rfsh_datapath #(
    .TICK_CYCLES (TICK_CYCLES),
    .BACKLOG_MAX (BACKLOG_MAX),
    .URGENT_LEVEL(URGENT_LEVEL),
    .ROW_BITS    (ROW_BITS),
    .RAS_ONLY    (RAS_ONLY)
  ) datapath_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .status (status),
    .rowAddr(rowAddr)
  );

  rfsh_control #(
    .SETUP_CYC  (SETUP_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRE_CYC    (PRE_CYC),
    .RAS_ONLY   (RAS_ONLY)
  ) control_i (
    .clk    (clk),
    .rstN   (rstN),
    .grantIn(grantIn),
    .status (status),
    .ctrl   (ctrl),
    .rasN   (rasN),
    .casN   (casN),
    .ownsBus(ownsBus)
  );

  assign reqOut    = status.pendingAny;
  assign urgentOut = status.pendingUrgent;
  assign weN       = 1'b1;
  assign addrDrive = RAS_ONLY && ownsBus;

endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker #(
  parameter bit RAS_ONLY    = 1'b0,
  parameter int RAS_LOW_CYC = 3,
  parameter int ROW_BITS    = 11
) (
  input logic                clk,
  input logic                rstN,
  input logic                grantIn,
  input logic                reqOut,
  input logic                urgentOut,
  input logic                rasN,
  input logic                casN,
  input logic                ownsBus,
  input logic                addrDrive,
  input logic [ROW_BITS-1:0] rowAddr
);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!rasN) begin
      if (lowRun != 16'hFFFF) lowRun <= lowRun + 16'd1;
    end else begin
      lowRun <= '0;
    end
  end

  // R1: strobes idle while the bus belongs to the access controller
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ownsBus |-> (rasN && casN && !addrDrive));

  // R4: urgency implies a pending request
  p_urgent_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    urgentOut |-> reqOut);

  // R5: a sequence begins only after request and grant met
  p_start_handshake_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownsBus) |-> $past(reqOut && grantIn));

  // R6: RAS held low at least the minimum pulse width
  p_ras_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowRun >= 16'(RAS_LOW_CYC)));

  // R6: precharge observed before the bus is handed back
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ownsBus) |-> $past(rasN && casN));

  // R9: row output only moves when a sequence ends
  p_row_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(ownsBus) |-> $stable(rowAddr));

  generate
    if (RAS_ONLY) begin : g_rasOnlyChecks
      // R9: CAS never drops in RAS-only refresh
      p_cas_high_r9: assert property (@(posedge clk) disable iff (!rstN)
        !rasN |-> (casN && addrDrive));
      // R9: each completed sequence advances the row by one
      p_row_step_r9: assert property (@(posedge clk) disable iff (!rstN)
        $fell(ownsBus) |-> (rowAddr == $past(rowAddr) + ROW_BITS'(1)));
    end else begin : g_cbrChecks
      // R6: CAS already low for a cycle when RAS falls
      p_cas_first_r6: assert property (@(posedge clk) disable iff (!rstN)
        $fell(rasN) |-> (!casN && $past(!casN)));
      // R8: no address ever driven with the internal row counter
      p_no_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
        ownsBus |-> (!addrDrive && (rowAddr == '0)));
    end
  endgenerate

endmodule

bind dram_refresh_sched rfsh_sched_checker #(
  .RAS_ONLY   (RAS_ONLY),
  .RAS_LOW_CYC(RAS_LOW_CYC),
  .ROW_BITS   (ROW_BITS)
) checker_i (
  .clk      (clk),
  .rstN     (rstN),
  .grantIn  (grantIn),
  .reqOut   (reqOut),
  .urgentOut(urgentOut),
  .rasN     (rasN),
  .casN     (casN),
  .ownsBus  (ownsBus),
  .addrDrive(addrDrive),
  .rowAddr  (rowAddr)
);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

  localparam int ROWB = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grant = 1'b0;
  logic grantRo = 1'b0;

  logic reqA, urgA, rasA, casA, weA, ownA, adrA;
  logic [ROWB-1:0] rowA;
  logic reqB, urgB, rasB, casB, weB, ownB, adrB;
  logic [ROWB-1:0] rowB;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  int seqCnt = 0;
  logic rasPrev = 1'b1;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .TICK_CYCLES(40), .BACKLOG_MAX(4), .URGENT_LEVEL(3),
    .SETUP_CYC(1), .RAS_LOW_CYC(3), .PRE_CYC(2),
    .ROW_BITS(ROWB), .RAS_ONLY(1'b0)
  ) dut_i (
    .clk(clk), .rstN(rstN), .grantIn(grant), .reqOut(reqA),
    .urgentOut(urgA), .rasN(rasA), .casN(casA), .weN(weA),
    .ownsBus(ownA), .addrDrive(adrA), .rowAddr(rowA)
  );

  dram_refresh_sched #(
    .TICK_CYCLES(40), .BACKLOG_MAX(4), .URGENT_LEVEL(3),
    .SETUP_CYC(1), .RAS_LOW_CYC(3), .PRE_CYC(2),
    .ROW_BITS(ROWB), .RAS_ONLY(1'b1)
  ) dut_ro_i (
    .clk(clk), .rstN(rstN), .grantIn(grantRo), .reqOut(reqB),
    .urgentOut(urgB), .rasN(rasB), .casN(casB), .weN(weB),
    .ownsBus(ownB), .addrDrive(adrB), .rowAddr(rowB)
  );

  always @(posedge clk) if (rstN) edgeNo <= edgeNo + 1;

  always @(negedge clk) begin
    if (rstN && rasPrev && !rasA) seqCnt++;
    rasPrev = rasA;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edgeNo);
    end
  endtask

  task automatic waitUntil(input int target);
    while (edgeNo < target) @(negedge clk);
  endtask

  // vector table: edge, expected reqOut, urgentOut, ownsBus (grant held low)
  localparam int NV = 6;
  localparam int VEC_EDGE [NV] = '{39, 40, 80, 120, 160, 240};
  localparam int VEC_REQ  [NV] = '{0, 1, 1, 1, 1, 1};
  localparam int VEC_URG  [NV] = '{0, 0, 0, 1, 1, 1};

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rasN", int'(rasA), 1);
    check("R1 casN", int'(casA), 1);
    check("R1 weN", int'(weA), 1);
    check("R1 reqOut", int'(reqA), 0);
    check("R1 urgentOut", int'(urgA), 0);
    check("R1 ownsBus", int'(ownA), 0);
    check("R1 addrDrive ras-only", int'(adrB), 0);
    rstN = 1'b1;

    // R2/R4 backlog growth with the grant withheld
    for (int i = 0; i < NV; i++) begin
      waitUntil(VEC_EDGE[i]);
      check("R2/R4 vector reqOut", int'(reqA), VEC_REQ[i]);
      check("R2/R4 vector urgentOut", int'(urgA), VEC_URG[i]);
      check("R5 vector no start without grant", int'(ownA), 0);
    end

    // grant at edge 241 with a saturated backlog of 4
    grant = 1'b1;
    waitUntil(241);
    check("R5 ownsBus after grant", int'(ownA), 1);
    check("R6 arm cycle casN high", int'(casA), 1);
    check("R6 arm cycle rasN high", int'(rasA), 1);
    waitUntil(242);
    check("R6 setup casN low", int'(casA), 0);
    check("R6 setup rasN high", int'(rasA), 1);
    waitUntil(243);
    check("R6 active rasN low", int'(rasA), 0);
    check("R6 active casN low", int'(casA), 0);
    check("R8 addrDrive low", int'(adrA), 0);
    check("R8 rowAddr zero", int'(rowA), 0);
    check("R6 weN high", int'(weA), 1);
    waitUntil(245);
    check("R6 active rasN last cycle", int'(rasA), 0);
    waitUntil(246);
    check("R6 precharge rasN", int'(rasA), 1);
    check("R6 precharge casN", int'(casA), 1);
    check("R6 precharge ownsBus", int'(ownA), 1);
    waitUntil(248);
    check("R5 bus released", int'(ownA), 0);
    waitUntil(249);
    check("R5 back-to-back restart", int'(ownA), 1);
    waitUntil(258);
    check("R4 urgency clears below level", int'(urgA), 0);
    check("R2 request still up", int'(reqA), 1);
    waitUntil(276);
    check("R3 saturated backlog drains in 4", seqCnt, 4);
    check("R3 request clear after drain", int'(reqA), 0);
    waitUntil(277);
    check("R10 grant without request idle", int'(ownA), 0);
    waitUntil(281);
    check("R2 new tick starts with grant held", int'(ownA), 1);
    waitUntil(288);
    grant = 1'b0;
    waitUntil(290);
    check("R7 count decremented", int'(reqA), 0);

    // R7 grant dropped after start
    waitUntil(320);
    grant = 1'b1;
    waitUntil(321);
    check("R5 start at 321", int'(ownA), 1);
    grant = 1'b0;
    waitUntil(323);
    check("R7 rasN low without grant", int'(rasA), 0);
    waitUntil(327);
    check("R7 still owning in precharge", int'(ownA), 1);
    waitUntil(328);
    check("R7 released", int'(ownA), 0);
    check("R7 request cleared", int'(reqA), 0);
    check("R7 sequence count", seqCnt, 6);

    // R9 RAS-only instance drains saturated backlog
    waitUntil(400);
    grantRo = 1'b1;
    waitUntil(402);
    check("R9 rasN low", int'(rasB), 0);
    check("R9 casN high", int'(casB), 1);
    check("R9 addrDrive", int'(adrB), 1);
    check("R9 first row", int'(rowB), 0);
    waitUntil(409);
    check("R9 second row", int'(rowB), 1);
    check("R9 casN high again", int'(casB), 1);
    waitUntil(416);
    check("R9 third row", int'(rowB), 2);
    waitUntil(430);
    check("R9 drained", int'(ownB), 0);
    check("R3 ras-only request clear", int'(reqB), 0);
    check("R9 row after four", int'(rowB), 4);
    grantRo = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule